// File: doc/BRIEF.md
# Programmable Clock Divider with Duty Control

The block derives a slow clock, such as a sample or left/right frame clock, from a fast input clock. Two configuration fields set it. The ratio field selects the output period, and the high-time field selects how many input cycles of each period the output spends high. A ratio field of zero turns the output off and holds it low.

Both fields are captured together at the start of every output period. Software may therefore rewrite them at any time, in any order, without producing short pulses. A build parameter removes the high-time field. In that build the high phase is derived from the ratio, which gives a duty cycle as close to half as the period allows.

Top module: `clk_duty_div`

## Requirements
- R1: When `div_cfg_i` is zero, `clk_o` is low after the next rising edge of `clk_i`, even in the middle of a period.
- R2: A nonzero ratio value N gives an output period of exactly N+1 input cycles.
- R3: Each period starts with its high phase. With high-time value H, where H is at most N, `clk_o` is high for H+1 cycles and then low for N-H cycles.
- R4: When H is equal to or greater than N, `clk_o` stays high for the whole period and never wraps to a short pattern.
- R5: The smallest ratio value, 1, divides by 2. The all-ones value of a `DIV_W`-bit field divides by 2^DIV_W.
- R6: `en_o` is high exactly when `div_cfg_i` is nonzero, in the same cycle, with no register delay.
- R7: Both fields are sampled together only at the start of a period. A change made mid-period leaves the current period unchanged, and the new values govern the following period.
- R8: When the ratio field leaves zero, `clk_o` goes high at the next rising edge of `clk_i`.
- R9: Asserting `rst_ni` low forces `clk_o` low at once and clears the period counter.
- R10: With `HAS_HIGH` = 0, `high_cfg_i` is ignored and the high phase lasts floor(N/2)+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_cfg_i | input | DIV_W | Ratio field; zero gates the output, N gives a period of N+1 cycles |
| high_cfg_i | input | DIV_W | High-time field; H gives H+1 high cycles per period |
| clk_o | output | 1 | Divided clock |
| en_o | output | 1 | High when the ratio field is nonzero |

## Verification
The bench drives these patterns:
- The smallest ratio, which shows whether the divider stops short of a full two-cycle period.
- Mid-range ratios with small high times, which separate an off-by-one error in the period from one in the high phase.
- High times equal to the ratio and above it, which show whether the high phase saturates or wraps.
- The all-ones ratio, which checks the largest period and that the counter does not overflow.

Field rewrites inside a period, a gate applied mid-period and a wake-up from the gated state show when configuration is sampled and how the output leaves and re-enters the off state. A second instance built without the high-time field runs on the same ratios. It receives a deliberately misleading high-time value, so any use of that field shows up as a wrong high phase.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;
endpackage

// File: rtl/clkdiv_hi_sel.sv
module clkdiv_hi_sel #(
  parameter int unsigned DIV_W    = 8,
  parameter bit          HAS_HIGH = 1'b1
) (
  input  logic [DIV_W-1:0] div_i,
  input  logic [DIV_W-1:0] high_i,
  output logic [DIV_W-1:0] high_o
);
  generate
    if (HAS_HIGH) begin : g_prog
      wire unused_div = ^div_i;
      assign high_o = high_i;
    end else begin : g_half
      // no high-time field: near-half duty from the ratio
      wire unused_high = ^high_i;
      assign high_o = div_i >> 1;
    end
  endgenerate
endmodule

// File: rtl/clkdiv_phase_cnt.sv
module clkdiv_phase_cnt
  import clkdiv_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] per_i,
  output logic [DIV_W-1:0] cnt_o,
  output phase_e           st_o,
  output logic             start_o
);
  assign start_o = run_i && ((st_o == PH_IDLE) || (cnt_o == per_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      st_o  <= PH_IDLE;
    end else if (!run_i) begin
      cnt_o <= '0;
      st_o  <= PH_IDLE;
    end else if (start_o) begin
      cnt_o <= '0;
      st_o  <= PH_RUN;
    end else begin
      cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/clkdiv_shape.sv
module clkdiv_shape #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             start_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [DIV_W-1:0] high_i,
  input  logic [DIV_W-1:0] cnt_i,
  output logic [DIV_W-1:0] per_o,
  output logic             clk_o
);
  logic [DIV_W-1:0] hi_q;
  logic [DIV_W:0]   nxt_cnt;

  assign nxt_cnt = {1'b0, cnt_i} + 1'b1;

  // both fields captured together, only at a period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_o <= '0;
      hi_q  <= '0;
    end else if (start_i) begin
      per_o <= div_i;
      hi_q  <= high_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      clk_o <= 1'b0;
    else if (!run_i)  clk_o <= 1'b0;
    else if (start_i) clk_o <= 1'b1;
    else              clk_o <= (nxt_cnt <= {1'b0, hi_q});
  end
endmodule

// File: rtl/clk_duty_div.sv
module clk_duty_div
  import clkdiv_pkg::*;
#(
  parameter int unsigned DIV_W    = 8,
  parameter bit          HAS_HIGH = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_cfg_i,
  input  logic [DIV_W-1:0] high_cfg_i,
  output logic             clk_o,
  output logic             en_o
);
  logic             run;
  logic             start;
  logic [DIV_W-1:0] high_sel;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] per_q;
  phase_e           st_q;

  assign run  = |div_cfg_i;
  assign en_o = run;

  clkdiv_hi_sel #(.DIV_W(DIV_W), .HAS_HIGH(HAS_HIGH)) u_hi_sel (
    .div_i (div_cfg_i),
    .high_i(high_cfg_i),
    .high_o(high_sel)
  );

  clkdiv_phase_cnt #(.DIV_W(DIV_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .per_i  (per_q),
    .cnt_o  (cnt_q),
    .st_o   (st_q),
    .start_o(start)
  );

  clkdiv_shape #(.DIV_W(DIV_W)) u_shape (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .start_i(start),
    .div_i  (div_cfg_i),
    .high_i (high_sel),
    .cnt_i  (cnt_q),
    .per_o  (per_q),
    .clk_o  (clk_o)
  );
endmodule

// File: rtl/clkdiv_chk.sv
module clkdiv_chk
  import clkdiv_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [DIV_W-1:0] div_cfg_i,
  input logic             clk_o,
  input logic             en_o,
  input logic [DIV_W-1:0] cnt_q,
  input logic [DIV_W-1:0] per_q,
  input phase_e           st_q
);
  AST_GATE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_cfg_i == '0) |=> !clk_o); // R1

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= per_q); // R2

  AST_RISE_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_o) |-> $past(en_o)); // R6

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> $stable(per_q)); // R7

  AST_WAKE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && st_q == PH_IDLE) |=> clk_o); // R8

  AST_RST_LOW: assert property (@(posedge clk_i)
    !rst_ni |-> (!clk_o && cnt_q == '0)); // R9
endmodule

bind clk_duty_div clkdiv_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .div_cfg_i(div_cfg_i),
  .clk_o    (clk_o),
  .en_o     (en_o),
  .cnt_q    (cnt_q),
  .per_q    (per_q),
  .st_q     (st_q)
);

// File: tb/tb_clk_duty_div.sv
`timescale 1ns/1ps
module tb_clk_duty_div;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] div_cfg = '0;
  logic [W-1:0] high_cfg = '0;
  logic         clk_out, en_out, clk_fx, en_fx;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic  exp_q[$];
  logic  fx_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  clk_duty_div #(.DIV_W(W), .HAS_HIGH(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .div_cfg_i(div_cfg), .high_cfg_i(high_cfg),
    .clk_o(clk_out), .en_o(en_out));

  clk_duty_div #(.DIV_W(W), .HAS_HIGH(1'b0)) dut_fix (
    .clk_i(clk), .rst_ni(rst_n), .div_cfg_i(div_cfg), .high_cfg_i(high_cfg),
    .clk_o(clk_fx), .en_o(en_fx));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: compare outputs after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() != 0) begin
        logic  e, ef;
        string t;
        e  = exp_q.pop_front();
        ef = fx_q.pop_front();
        t  = tag_q.pop_front();
        chk(clk_out === e, t, int'(clk_out), int'(e));
        chk(clk_fx === ef, "R10", int'(clk_fx), int'(ef));
      end
    end
  end

  // drive one cycle of inputs and push the values expected after the next edge
  task automatic drive_cycle(input int n, input int h, input logic e, input logic ef,
                             input string t);
    @(negedge clk);
    div_cfg  = W'(n);
    high_cfg = W'(h);
    exp_q.push_back(e);
    fx_q.push_back(ef);
    tag_q.push_back(t);
    #1;
    chk(en_out === (n != 0), "R6", int'(en_out), int'(n != 0));
  endtask

  task automatic run_cfg(input int n, input int h, input int periods, input string t);
    int hs;
    hs = (h > n) ? n : h;
    for (int p = 0; p < periods; p++)
      for (int c = 0; c <= n; c++)
        drive_cycle(n, h, c <= hs, c <= (n >> 1), t);
  endtask

  task automatic gate(input int cycles);
    for (int c = 0; c < cycles; c++) drive_cycle(0, 0, 1'b0, 1'b0, "R1");
  endtask

  // fields rewritten at cycle sw of a period: old pattern must finish (R7)
  task automatic run_switch(input int n0, input int h0, input int n1, input int h1,
                            input int sw);
    for (int c = 0; c <= n0; c++) begin
      if (c < sw) drive_cycle(n0, h0, c <= h0, c <= (n0 >> 1), "R7");
      else        drive_cycle(n1, h1, c <= h0, c <= (n0 >> 1), "R7");
    end
    run_cfg(n1, h1, 1, "R7");
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(clk_out === 1'b0, "R9", int'(clk_out), 0);
    chk(en_out === 1'b0, "R6", int'(en_out), 0);
    rst_n = 1'b1;

    run_cfg(1, 0, 3, "R5");     // divide by 2
    run_cfg(3, 1, 2, "R2");
    run_cfg(4, 0, 2, "R3");
    run_cfg(5, 2, 2, "R3");
    run_cfg(3, 3, 2, "R4");     // H == N
    run_cfg(2, 7, 2, "R4");     // H > N
    run_switch(4, 1, 2, 0, 2);
    run_switch(2, 0, 6, 5, 1);
    // gate mid-period, then wake up
    drive_cycle(5, 2, 1'b1, 1'b1, "R3");
    drive_cycle(5, 2, 1'b1, 1'b1, "R3");
    gate(3);
    run_cfg(2, 0, 2, "R8");
    gate(2);
    run_cfg(255, 100, 1, "R5"); // all ones: divide by 256
    run_cfg(1, 1, 1, "R5");
    drain();

    // asynchronous reset in the middle of a period
    div_cfg = W'(6);
    high_cfg = W'(4);
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(clk_out === 1'b0, "R9", int'(clk_out), 0);
    chk(clk_fx === 1'b0, "R9", int'(clk_fx), 0);
    div_cfg = '0;
    @(negedge clk);
    rst_n = 1'b1;
    run_cfg(3, 0, 1, "R9");     // fresh start after reset
    drain();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule